// File: doc/BRIEF.md
# Strobed Dual-Channel Serial Voice Port

This block is the serial edge of a two-channel voice transcoder. One serial input carries 8-bit PCM samples for channels B1 and B2, each framed by its own enable strobe. A second serial input carries compressed ADPCM words for both channels, framed by a shared strobe. Two serial outputs return the matching PCM and ADPCM data in the same windows. The block runs on a fast system clock. It watches the slower bit clock for its edges, so no bit rate or frame length is assumed. Data is captured on the falling bit-clock edge and launched on the rising one.

Toward the transcoder core, each channel has a parallel PCM register and a parallel ADPCM register, each with a one-cycle valid pulse. The core supplies the words to send back. A 2-bit mode code per channel selects one of four behaviours:

- 00: hold the channel in reset and send an idle code.
- 01: bypass, looping the received PCM byte back out on the next frame.
- 10: 3-bit ADPCM words.
- 11: 4-bit ADPCM words.

Law and format inputs choose how PCM bytes are bit-inverted on the line. An active-low power-down input halts the block and drops the output pad enables.

Top module: `svp_port`

## Requirements
- R1: While a channel's PCM strobe is high, each falling bit-clock edge shifts one bit of `pcm_rx` in, MSB first. When the 8th bit arrives, the channel's `rx_pcm_*` word is updated and its `rx_pcm_vld` bit (bit 0 = B1, bit 1 = B2) pulses for one clock. This happens only when the channel's mode is 10 or 11.
- R2: On each rising bit-clock edge inside a channel's PCM strobe window, `pcm_tx` presents the next bit of that channel's outgoing byte, MSB first. The bit appears one system clock after the edge is seen.
- R3: With `fmt_std` high, line bytes are XORed with 0x55 when `law_a` is high and with 0x7F when it is low. With `fmt_std` low, no inversion is applied. The same mask is used on received bytes (line to core) and on transmitted core bytes (core to line).
- R4: In mode 00 the channel sends the idle line code: 0xD5 when `law_a` is high, 0xFF when it is low. Neither valid bit of the channel pulses.
- R5: In mode 01 the channel sends, without alteration, the line byte it last received in full. That byte comes from the previous frame. No valid bit of the channel pulses.
- R6: The ADPCM word width is 3 bits in mode 10, 4 bits in mode 11, and 0 bits (no slot) in modes 00 and 01. Inside the `stb_adp` window, B1's word comes first and B2's follows immediately, each MSB first. A received word is zero-extended onto `rx_adp_*`, and its `rx_adp_vld` bit pulses once.
- R7: `adp_tx` sends B1's core word and then B2's, using the same widths and order as R6. Both words are latched at the first rising edge of the window.
- R8: If a PCM strobe is seen low at a falling edge after 1 to 7 bits of that channel were taken, that channel's `frm_err` bit pulses. No PCM valid is issued, and the stored bypass byte is left unchanged.
- R9: While `pwr_n` is low, all counters and stored bytes clear, including the bypass byte, and no valid or error pulses occur. From the next clock, `pcm_tx_en` and `adp_tx_en` are low.
- R10: Behaviour depends only on bit-clock edges, not on how many system clocks each bit lasts.
- R11: Outside every active slot, both serial outputs drive 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_n | input | 1 | Active-low power-down |
| bclk | input | 1 | Serial bit clock |
| law_a | input | 1 | 1 selects A-law, 0 selects mu-law |
| fmt_std | input | 1 | 1 selects standard coding, 0 selects sign-magnitude |
| mode_b1 | input | 2 | B1 mode code |
| mode_b2 | input | 2 | B2 mode code |
| stb_b1 | input | 1 | B1 PCM slot strobe |
| stb_b2 | input | 1 | B2 PCM slot strobe |
| stb_adp | input | 1 | Shared ADPCM window strobe |
| pcm_rx | input | 1 | Serial PCM input |
| adp_rx | input | 1 | Serial ADPCM input |
| pcm_tx | output | 1 | Serial PCM output data |
| pcm_tx_en | output | 1 | Pad drive enable for pcm_tx |
| adp_tx | output | 1 | Serial ADPCM output data |
| adp_tx_en | output | 1 | Pad drive enable for adp_tx |
| tx_pcm_b1 | input | 8 | Core PCM byte to send on B1 |
| tx_pcm_b2 | input | 8 | Core PCM byte to send on B2 |
| tx_adp_b1 | input | 4 | Core ADPCM word to send for B1 |
| tx_adp_b2 | input | 4 | Core ADPCM word to send for B2 |
| rx_pcm_b1 | output | 8 | Received B1 PCM byte, converted |
| rx_pcm_b2 | output | 8 | Received B2 PCM byte, converted |
| rx_pcm_vld | output | 2 | PCM valid pulses, bit 0 = B1 |
| rx_adp_b1 | output | 4 | Received B1 ADPCM word |
| rx_adp_b2 | output | 4 | Received B2 ADPCM word |
| rx_adp_vld | output | 2 | ADPCM valid pulses, bit 0 = B1 |
| frm_err | output | 2 | Short-strobe pulses, bit 0 = B1 |

## Verification
Eight frames walk all four mode codes on each channel, in differing pairs, across all three law and format combinations. This separates the 0x55 mask, the 0x7F mask and no mask, and it shows the B2 ADPCM word moving with B1's width of 0, 3 or 4. Bypass frames follow frames with distinct bytes, so a loop of the current byte or of the core byte would be caught. A frame with a longer bit period repeats the main path. A five-bit B1 strobe followed by a bypass frame shows that the aborted byte neither raises a valid nor reaches the loop. A powered-down frame followed by a bypass frame shows that stored state was cleared.

// File: rtl/svp_pkg.sv
package svp_pkg;
    typedef enum logic [1:0] {
        MODE_RST = 2'b00,
        MODE_BYP = 2'b01,
        MODE_R24 = 2'b10,
        MODE_R32 = 2'b11
    } mode_e;

    localparam int ADP_W24 = 3;
    localparam int ADP_W32 = 4;
endpackage

// File: rtl/svp_edge.sv
module svp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic lvl;
    } edge_st;

    edge_st st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = bclk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = bclk & ~st_q.lvl;
    assign fall = ~bclk & st_q.lvl;
endmodule

// File: rtl/svp_pcm_lane.sv
module svp_pcm_lane import svp_pkg::*; #(
    parameter int W = 8,
    parameter logic [W-1:0] IDLE_A = 8'hD5,
    parameter logic [W-1:0] IDLE_U = 8'hFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         rise,
    input  logic         fall,
    input  logic         stb,
    input  logic         rx_bit,
    input  mode_e        mode,
    input  logic         law_a,
    input  logic         fmt_std,
    input  logic [W-1:0] core_word,
    output logic [W-1:0] word,
    output logic         vld,
    output logic         err,
    output logic         tx_bit,
    output logic         tx_act
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] FULL = CW'(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [CW-1:0] rcnt;
        logic [W-1:0]  rsh;
        logic [W-1:0]  loopb;
        logic [W-1:0]  word;
        logic          vld;
        logic          err;
        logic [CW-1:0] tcnt;
        logic [W-1:0]  tsh;
        logic          tbit;
        logic          tact;
    } lane_st;

    lane_st st_d, st_q;

    function automatic logic [W-1:0] line_mask(input logic a, input logic std);
        logic [W-1:0] m;
        m = '0;
        if (std) begin
            for (int i = 0; i < W; i++) begin
                m[i] = a ? (i % 2 == 0) : (i != W - 1);
            end
        end
        return m;
    endfunction

    always_comb begin
        logic [W-1:0] mask;
        logic [W-1:0] full_rx;
        logic [W-1:0] out_w;

        mask    = line_mask(law_a, fmt_std);
        full_rx = {st_q.rsh[W-2:0], rx_bit};
        case (mode)
            MODE_RST: out_w = law_a ? IDLE_A : IDLE_U;
            MODE_BYP: out_w = st_q.loopb;
            default:  out_w = core_word ^ mask;
        endcase

        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.err = 1'b0;

        if (!run) begin
            st_d = '0;
        end else begin
            if (fall) begin
                if (stb) begin
                    if (st_q.rcnt != FULL) begin
                        st_d.rsh  = full_rx;
                        st_d.rcnt = st_q.rcnt + 1'b1;
                        if (st_q.rcnt == LAST) begin
                            st_d.loopb = full_rx;
                            if (mode[1]) begin
                                st_d.vld  = 1'b1;
                                st_d.word = full_rx ^ mask;
                            end
                        end
                    end
                end else begin
                    if (st_q.rcnt != '0 && st_q.rcnt != FULL) st_d.err = 1'b1;
                    st_d.rcnt = '0;
                end
            end
            if (rise) begin
                if (stb) begin
                    if (st_q.tcnt == '0) begin
                        st_d.tbit = out_w[W-1];
                        st_d.tsh  = out_w << 1;
                        st_d.tcnt = CW'(1);
                        st_d.tact = 1'b1;
                    end else if (st_q.tcnt != FULL) begin
                        st_d.tbit = st_q.tsh[W-1];
                        st_d.tsh  = st_q.tsh << 1;
                        st_d.tcnt = st_q.tcnt + 1'b1;
                        st_d.tact = 1'b1;
                    end else begin
                        st_d.tact = 1'b0;
                    end
                end else begin
                    st_d.tcnt = '0;
                    st_d.tact = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word   = st_q.word;
    assign vld    = st_q.vld;
    assign err    = st_q.err;
    assign tx_bit = st_q.tbit;
    assign tx_act = st_q.tact;
endmodule

// File: rtl/svp_adp_lane.sv
module svp_adp_lane import svp_pkg::*; #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          rise,
    input  logic          fall,
    input  logic          stb,
    input  logic          rx_bit,
    input  mode_e         mode_b1,
    input  mode_e         mode_b2,
    input  logic [AW-1:0] core_b1,
    input  logic [AW-1:0] core_b2,
    output logic [AW-1:0] word_b1,
    output logic [AW-1:0] word_b2,
    output logic [1:0]    vld,
    output logic          tx_bit,
    output logic          tx_act
);
    localparam int SPAN = 2 * AW;
    localparam int CW   = $clog2(SPAN + 1);

    typedef struct packed {
        logic [CW-1:0] rcnt;
        logic [CW-1:0] tcnt;
        logic [AW-1:0] sh1;
        logic [AW-1:0] sh2;
        logic [AW-1:0] word1;
        logic [AW-1:0] word2;
        logic [AW-1:0] hold1;
        logic [AW-1:0] hold2;
        logic [1:0]    vld;
        logic          tbit;
        logic          tact;
    } adp_st;

    adp_st st_d, st_q;

    function automatic logic [CW-1:0] wlen(input mode_e m);
        case (m)
            MODE_R24: return CW'(ADP_W24);
            MODE_R32: return CW'(ADP_W32);
            default:  return '0;
        endcase
    endfunction

    function automatic logic pick(input logic [AW-1:0] w, input logic [CW-1:0] len,
                                  input logic [CW-1:0] pos);
        logic r;
        r = 1'b0;
        for (int k = 0; k < AW; k++) begin
            if (CW'(k) + pos + CW'(1) == len) r = w[k];
        end
        return r;
    endfunction

    always_comb begin
        logic [CW-1:0] w1;
        logic [CW-1:0] w2;
        logic [CW-1:0] tot;
        logic [AW-1:0] nsh;
        logic [AW-1:0] src1;
        logic [AW-1:0] src2;

        w1   = wlen(mode_b1);
        w2   = wlen(mode_b2);
        tot  = w1 + w2;
        nsh  = '0;
        src1 = (st_q.tcnt == '0) ? core_b1 : st_q.hold1;
        src2 = (st_q.tcnt == '0) ? core_b2 : st_q.hold2;

        st_d     = st_q;
        st_d.vld = 2'b00;

        if (!run) begin
            st_d = '0;
        end else begin
            if (fall) begin
                if (stb) begin
                    if (st_q.rcnt < tot) begin
                        if (st_q.rcnt < w1) begin
                            nsh = (st_q.rcnt == '0) ? {{(AW-1){1'b0}}, rx_bit}
                                                    : {st_q.sh1[AW-2:0], rx_bit};
                            st_d.sh1 = nsh;
                            if (st_q.rcnt == w1 - 1'b1) begin
                                st_d.vld[0] = 1'b1;
                                st_d.word1  = nsh;
                            end
                        end else begin
                            nsh = (st_q.rcnt == w1) ? {{(AW-1){1'b0}}, rx_bit}
                                                    : {st_q.sh2[AW-2:0], rx_bit};
                            st_d.sh2 = nsh;
                            if (st_q.rcnt == tot - 1'b1) begin
                                st_d.vld[1] = 1'b1;
                                st_d.word2  = nsh;
                            end
                        end
                        st_d.rcnt = st_q.rcnt + 1'b1;
                    end
                end else begin
                    st_d.rcnt = '0;
                end
            end
            if (rise) begin
                if (stb) begin
                    if (st_q.tcnt == '0) begin
                        st_d.hold1 = core_b1;
                        st_d.hold2 = core_b2;
                    end
                    if (st_q.tcnt < tot) begin
                        st_d.tact = 1'b1;
                        st_d.tbit = (st_q.tcnt < w1) ? pick(src1, w1, st_q.tcnt)
                                                     : pick(src2, w2, st_q.tcnt - w1);
                        st_d.tcnt = st_q.tcnt + 1'b1;
                    end else begin
                        st_d.tact = 1'b0;
                    end
                end else begin
                    st_d.tcnt = '0;
                    st_d.tact = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_b1 = st_q.word1;
    assign word_b2 = st_q.word2;
    assign vld     = st_q.vld;
    assign tx_bit  = st_q.tbit;
    assign tx_act  = st_q.tact;
endmodule

// File: rtl/svp_port.sv
module svp_port import svp_pkg::*; #(
    parameter int PCM_W = 8,
    parameter int ADP_W = 4,
    parameter logic [PCM_W-1:0] IDLE_A = 8'hD5,
    parameter logic [PCM_W-1:0] IDLE_U = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_n,
    input  logic             bclk,
    input  logic             law_a,
    input  logic             fmt_std,
    input  logic [1:0]       mode_b1,
    input  logic [1:0]       mode_b2,
    input  logic             stb_b1,
    input  logic             stb_b2,
    input  logic             stb_adp,
    input  logic             pcm_rx,
    input  logic             adp_rx,
    output logic             pcm_tx,
    output logic             pcm_tx_en,
    output logic             adp_tx,
    output logic             adp_tx_en,
    input  logic [PCM_W-1:0] tx_pcm_b1,
    input  logic [PCM_W-1:0] tx_pcm_b2,
    input  logic [ADP_W-1:0] tx_adp_b1,
    input  logic [ADP_W-1:0] tx_adp_b2,
    output logic [PCM_W-1:0] rx_pcm_b1,
    output logic [PCM_W-1:0] rx_pcm_b2,
    output logic [1:0]       rx_pcm_vld,
    output logic [ADP_W-1:0] rx_adp_b1,
    output logic [ADP_W-1:0] rx_adp_b2,
    output logic [1:0]       rx_adp_vld,
    output logic [1:0]       frm_err
);
    localparam int NCH = 2;

    typedef struct packed {
        logic en;
    } top_st;

    top_st st_d, st_q;

    logic rise, fall;
    logic             stb_v  [NCH];
    mode_e            mode_v [NCH];
    logic [PCM_W-1:0] core_v [NCH];
    logic [PCM_W-1:0] word_v [NCH];
    logic [NCH-1:0]   tbit_v, tact_v;
    logic             adp_bit, adp_act;

    assign stb_v[0]  = stb_b1;
    assign stb_v[1]  = stb_b2;
    assign mode_v[0] = mode_e'(mode_b1);
    assign mode_v[1] = mode_e'(mode_b2);
    assign core_v[0] = tx_pcm_b1;
    assign core_v[1] = tx_pcm_b2;

    svp_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .bclk  (bclk),
        .rise  (rise),
        .fall  (fall)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        svp_pcm_lane #(
            .W      (PCM_W),
            .IDLE_A (IDLE_A),
            .IDLE_U (IDLE_U)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (pwr_n),
            .rise      (rise),
            .fall      (fall),
            .stb       (stb_v[g]),
            .rx_bit    (pcm_rx),
            .mode      (mode_v[g]),
            .law_a     (law_a),
            .fmt_std   (fmt_std),
            .core_word (core_v[g]),
            .word      (word_v[g]),
            .vld       (rx_pcm_vld[g]),
            .err       (frm_err[g]),
            .tx_bit    (tbit_v[g]),
            .tx_act    (tact_v[g])
        );
    end

    svp_adp_lane #(.AW(ADP_W)) u_adp (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (pwr_n),
        .rise    (rise),
        .fall    (fall),
        .stb     (stb_adp),
        .rx_bit  (adp_rx),
        .mode_b1 (mode_v[0]),
        .mode_b2 (mode_v[1]),
        .core_b1 (tx_adp_b1),
        .core_b2 (tx_adp_b2),
        .word_b1 (rx_adp_b1),
        .word_b2 (rx_adp_b2),
        .vld     (rx_adp_vld),
        .tx_bit  (adp_bit),
        .tx_act  (adp_act)
    );

    always_comb begin
        st_d    = st_q;
        st_d.en = pwr_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_pcm_b1 = word_v[0];
    assign rx_pcm_b2 = word_v[1];
    assign pcm_tx    = tact_v[0] ? tbit_v[0] : (tact_v[1] ? tbit_v[1] : 1'b1);
    assign adp_tx    = adp_act ? adp_bit : 1'b1;
    assign pcm_tx_en = st_q.en;
    assign adp_tx_en = st_q.en;
endmodule

// File: rtl/svp_chk.sv
module svp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_n,
    input logic       stb_b1,
    input logic       stb_b2,
    input logic [1:0] mode_b1,
    input logic [1:0] mode_b2,
    input logic       pcm_tx_en,
    input logic       adp_tx_en,
    input logic [1:0] rx_pcm_vld,
    input logic [1:0] rx_adp_vld,
    input logic [1:0] frm_err
);
    AST_PCM1_VLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pcm_vld[0] |-> $past(mode_b1[1])); // R1
    AST_PCM2_VLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pcm_vld[1] |-> $past(mode_b2[1])); // R1
    AST_PCM_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pcm_vld[0] |=> !rx_pcm_vld[0]); // R1
    AST_ADP1_VLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_adp_vld[0] |-> $past(mode_b1[1])); // R6
    AST_ADP2_VLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_adp_vld[1] |-> $past(mode_b2[1])); // R6
    AST_ERR1_STROBE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err[0] |-> $past(!stb_b1)); // R8
    AST_ERR2_STROBE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err[1] |-> $past(!stb_b2)); // R8
    AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err[0] |-> !rx_pcm_vld[0]); // R8
    AST_POWER_DOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_n |=> (!pcm_tx_en && !adp_tx_en && rx_pcm_vld == 2'b00
                    && rx_adp_vld == 2'b00 && frm_err == 2'b00)); // R9
endmodule

bind svp_port svp_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_n      (pwr_n),
    .stb_b1     (stb_b1),
    .stb_b2     (stb_b2),
    .mode_b1    (mode_b1),
    .mode_b2    (mode_b2),
    .pcm_tx_en  (pcm_tx_en),
    .adp_tx_en  (adp_tx_en),
    .rx_pcm_vld (rx_pcm_vld),
    .rx_adp_vld (rx_adp_vld),
    .frm_err    (frm_err)
);

// File: tb/sim_svp_port.sv
module sim_svp_port;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, pwr_n, bclk, law_a, fmt_std;
    logic [1:0] mode_b1, mode_b2;
    logic stb_b1, stb_b2, stb_adp, pcm_rx, adp_rx;
    logic pcm_tx, pcm_tx_en, adp_tx, adp_tx_en;
    logic [7:0] tx_pcm_b1, tx_pcm_b2, rx_pcm_b1, rx_pcm_b2;
    logic [3:0] tx_adp_b1, tx_adp_b2, rx_adp_b1, rx_adp_b2;
    logic [1:0] rx_pcm_vld, rx_adp_vld, frm_err;

    svp_port u0 (
        .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .bclk(bclk), .law_a(law_a),
        .fmt_std(fmt_std), .mode_b1(mode_b1), .mode_b2(mode_b2),
        .stb_b1(stb_b1), .stb_b2(stb_b2), .stb_adp(stb_adp),
        .pcm_rx(pcm_rx), .adp_rx(adp_rx), .pcm_tx(pcm_tx), .pcm_tx_en(pcm_tx_en),
        .adp_tx(adp_tx), .adp_tx_en(adp_tx_en), .tx_pcm_b1(tx_pcm_b1),
        .tx_pcm_b2(tx_pcm_b2), .tx_adp_b1(tx_adp_b1), .tx_adp_b2(tx_adp_b2),
        .rx_pcm_b1(rx_pcm_b1), .rx_pcm_b2(rx_pcm_b2), .rx_pcm_vld(rx_pcm_vld),
        .rx_adp_b1(rx_adp_b1), .rx_adp_b2(rx_adp_b2), .rx_adp_vld(rx_adp_vld),
        .frm_err(frm_err)
    );

    typedef struct packed {
        logic [1:0] m1;
        logic [1:0] m2;
        logic       law;
        logic       fmt;
        logic [7:0] rx1;
        logic [7:0] rx2;
        logic [7:0] c1;
        logic [7:0] c2;
        logic [7:0] arx;
        logic [3:0] ca1;
        logic [3:0] ca2;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{2'd3, 2'd3, 1'b1, 1'b1, 8'hA5, 8'h3C, 8'h81, 8'h7E, 8'hB3, 4'h9, 4'h6},
        '{2'd2, 2'd2, 1'b0, 1'b1, 8'h5A, 8'hC3, 8'h12, 8'hED, 8'h6D, 4'h5, 4'h2},
        '{2'd1, 2'd1, 1'b1, 1'b0, 8'hF0, 8'h0F, 8'h00, 8'hFF, 8'h00, 4'h0, 4'h0},
        '{2'd0, 2'd3, 1'b0, 1'b0, 8'h99, 8'h66, 8'h55, 8'hAA, 8'hE4, 4'hF, 4'hA},
        '{2'd3, 2'd0, 1'b1, 1'b1, 8'h01, 8'h80, 8'hC8, 8'h37, 8'h5C, 4'hC, 4'h3},
        '{2'd1, 2'd2, 1'b0, 1'b1, 8'h77, 8'h88, 8'h24, 8'hDB, 8'hA9, 4'h1, 4'h7},
        '{2'd2, 2'd3, 1'b1, 1'b1, 8'hE1, 8'h1E, 8'h6B, 8'h94, 8'h39, 4'h6, 4'hB},
        '{2'd3, 2'd1, 1'b0, 1'b0, 8'h4D, 8'hB2, 8'hF3, 8'h0C, 8'hC7, 4'hE, 4'h8}
    };

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    int n_pv1, n_pv2, n_av1, n_av2, n_err;
    logic [7:0] got_p1, got_p2;
    logic [3:0] got_a1, got_a2;
    logic [7:0] prev1, prev2;

    always @(negedge clk) begin
        if (rx_pcm_vld[0]) begin n_pv1++; got_p1 = rx_pcm_b1; end
        if (rx_pcm_vld[1]) begin n_pv2++; got_p2 = rx_pcm_b2; end
        if (rx_adp_vld[0]) begin n_av1++; got_a1 = rx_adp_b1; end
        if (rx_adp_vld[1]) begin n_av2++; got_a2 = rx_adp_b2; end
        if (frm_err != 2'b00) n_err++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(input logic law, input logic fmt);
        if (!fmt) return 8'h00;
        return law ? 8'h55 : 8'h7F;
    endfunction

    function automatic int wl(input logic [1:0] m);
        return (m == 2'd2) ? 3 : ((m == 2'd3) ? 4 : 0);
    endfunction

    task automatic clear_counts();
        n_pv1 = 0; n_pv2 = 0; n_av1 = 0; n_av2 = 0; n_err = 0;
    endtask

    task automatic bitp(input logic pb, input logic ab, input logic s1, input logic s2,
                        input logic sa, input int half, output logic tp, output logic ta);
        @(negedge clk);
        pcm_rx = pb; adp_rx = ab; stb_b1 = s1; stb_b2 = s2; stb_adp = sa; bclk = 1'b1;
        repeat (half - 1) @(negedge clk);
        tp = pcm_tx; ta = adp_tx;
        @(negedge clk);
        bclk = 1'b0;
        repeat (half - 1) @(negedge clk);
    endtask

    task automatic run_frame(input vec_t v, input int half, output logic [7:0] t1,
                             output logic [7:0] t2, output logic [7:0] ta8,
                             output logic gp, output logic ga);
        logic tp, ta;
        mode_b1 = v.m1; mode_b2 = v.m2; law_a = v.law; fmt_std = v.fmt;
        tx_pcm_b1 = v.c1; tx_pcm_b2 = v.c2; tx_adp_b1 = v.ca1; tx_adp_b2 = v.ca2;
        clear_counts();
        for (int i = 0; i < 8; i++) begin
            bitp(v.rx1[7-i], 1'b0, 1'b1, 1'b0, 1'b0, half, tp, ta);
            t1[7-i] = tp;
        end
        for (int i = 0; i < 8; i++) begin
            bitp(v.rx2[7-i], 1'b0, 1'b0, 1'b1, 1'b0, half, tp, ta);
            t2[7-i] = tp;
        end
        for (int i = 0; i < 8; i++) begin
            bitp(1'b0, v.arx[7-i], 1'b0, 1'b0, 1'b1, half, tp, ta);
            ta8[7-i] = ta;
        end
        bitp(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, half, gp, ga);
        bitp(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, half, tp, ta);
    endtask

    function automatic logic [7:0] exp_pcm_tx(input logic [1:0] m, input logic law,
                                              input logic fmt, input logic [7:0] core,
                                              input logic [7:0] prev);
        case (m)
            2'd0:    return law ? 8'hD5 : 8'hFF;
            2'd1:    return prev;
            default: return core ^ mask_of(law, fmt);
        endcase
    endfunction

    task automatic check_frame(input vec_t v, input logic [7:0] t1, input logic [7:0] t2,
                               input logic [7:0] ta8, input logic gp, input logic ga);
        int w1, w2;
        logic [3:0] e1, e2;
        logic [7:0] eta;
        w1 = wl(v.m1); w2 = wl(v.m2);
        // R2 R3 R4 R5: transmitted PCM slots
        chk("R2/R3/R4/R5 b1 pcm tx", t1, exp_pcm_tx(v.m1, v.law, v.fmt, v.c1, prev1));
        chk("R2/R3/R4/R5 b2 pcm tx", t2, exp_pcm_tx(v.m2, v.law, v.fmt, v.c2, prev2));
        // R1 R3: received PCM
        chk("R1 b1 pcm vld count", n_pv1, v.m1[1] ? 1 : 0);
        chk("R1 b2 pcm vld count", n_pv2, v.m2[1] ? 1 : 0);
        if (v.m1[1]) chk("R3 b1 pcm rx word", got_p1, v.rx1 ^ mask_of(v.law, v.fmt));
        if (v.m2[1]) chk("R3 b2 pcm rx word", got_p2, v.rx2 ^ mask_of(v.law, v.fmt));
        // R6: received ADPCM
        e1 = '0; e2 = '0;
        for (int k = 0; k < w1; k++) e1 = {e1[2:0], v.arx[7-k]};
        for (int k = w1; k < w1 + w2; k++) e2 = {e2[2:0], v.arx[7-k]};
        chk("R6 b1 adp vld count", n_av1, (w1 > 0) ? 1 : 0);
        chk("R6 b2 adp vld count", n_av2, (w2 > 0) ? 1 : 0);
        if (w1 > 0) chk("R6 b1 adp rx word", got_a1, e1);
        if (w2 > 0) chk("R6 b2 adp rx word", got_a2, e2);
        // R7: transmitted ADPCM
        for (int i = 0; i < 8; i++) begin
            if (i < w1)           eta[7-i] = v.ca1[w1-1-i];
            else if (i < w1 + w2) eta[7-i] = v.ca2[w2-1-(i-w1)];
            else                  eta[7-i] = 1'b1;
        end
        chk("R7 adp tx bits", ta8, eta);
        chk("R8 no framing error on full frame", n_err, 0);
        chk("R11 idle line outside slots", {gp, ga}, 2'b11);
        prev1 = v.rx1; prev2 = v.rx2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired before the bench completed");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] t1, t2, ta8;
        logic gp, ga, tp, ta;
        vec_t v;
        rst_n = 1'b0; pwr_n = 1'b1; bclk = 1'b0; law_a = 1'b0; fmt_std = 1'b0;
        mode_b1 = 2'd0; mode_b2 = 2'd0; stb_b1 = 1'b0; stb_b2 = 1'b0; stb_adp = 1'b0;
        pcm_rx = 1'b0; adp_rx = 1'b0; tx_pcm_b1 = '0; tx_pcm_b2 = '0;
        tx_adp_b1 = '0; tx_adp_b2 = '0; prev1 = '0; prev2 = '0;
        clear_counts();
        repeat (4) @(negedge clk);
        chk("R9 enables low in reset", {pcm_tx_en, adp_tx_en}, 2'b00);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 enables high after reset", {pcm_tx_en, adp_tx_en}, 2'b11);
        chk("R11 reset line idle", {pcm_tx, adp_tx}, 2'b11);
        chk("R1 no valid after reset", {rx_pcm_vld, rx_adp_vld, frm_err}, 6'd0);

        // table walk
        for (int n = 0; n < 8; n++) begin
            run_frame(VEC[n], 4, t1, t2, ta8, gp, ga);
            check_frame(VEC[n], t1, t2, ta8, gp, ga);
        end

        // R10: slower bit clock, same results
        run_frame(VEC[6], 11, t1, t2, ta8, gp, ga);
        chk("R10 slow bclk b1 pcm tx", t1, exp_pcm_tx(VEC[6].m1, 1'b1, 1'b1, VEC[6].c1, prev1));
        check_frame(VEC[6], t1, t2, ta8, gp, ga);

        // R8: short B1 strobe in bypass mode
        v = VEC[2];
        run_frame(v, 4, t1, t2, ta8, gp, ga);
        check_frame(v, t1, t2, ta8, gp, ga);
        clear_counts();
        mode_b1 = 2'd3;
        for (int i = 0; i < 5; i++) bitp(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4, tp, ta);
        bitp(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4, tp, ta);
        bitp(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4, tp, ta);
        chk("R8 short strobe error pulses", n_err, 1);
        chk("R8 short strobe gives no valid", n_pv1, 0);
        v.rx1 = 8'h3E;
        run_frame(v, 4, t1, t2, ta8, gp, ga);
        chk("R8 bypass byte unchanged by short strobe", t1, prev1);
        prev1 = v.rx1; prev2 = v.rx2;

        // R9: power down
        @(negedge clk);
        pwr_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 enables drop in power-down", {pcm_tx_en, adp_tx_en}, 2'b00);
        run_frame(VEC[0], 4, t1, t2, ta8, gp, ga);
        chk("R9 no valids in power-down", n_pv1 + n_pv2 + n_av1 + n_av2 + n_err, 0);
        pwr_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 enables return", {pcm_tx_en, adp_tx_en}, 2'b11);
        prev1 = '0; prev2 = '0;
        v = VEC[2];
        run_frame(v, 4, t1, t2, ta8, gp, ga);
        chk("R9 bypass byte cleared b1", t1, 8'h00);
        chk("R9 bypass byte cleared b2", t2, 8'h00);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule